// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Shared RAM

This block holds 4096 bits of storage that two fully independent ports reach at different widths. The narrow port sees 1024 words of 4 bits. The wide port sees 256 words of 16 bits. Data written through one port can be read back through the other, so the block converts between a 4-bit stream and a 16-bit stream with no extra logic around it.

Each port has its own clock, enable, write enable, synchronous output reset, address, write data and registered read data. Both ports may read and write in the same cycle. The address spaces can also be split into halves: if the narrow port keeps its address MSB high and the wide port keeps its MSB low, the two ports act as two separate memories that never touch each other.

Internally the storage is built as two banks, each written by only one port. The stored value is the XOR of the two banks. A write through one port stores the new data XORed with the other bank's current contents. This keeps every storage bit under a single clock and still lets a port's write be seen by both readers.

Top module: `mwram_tdp`

## Requirements
- R1: Narrow address `a` (10 bits) selects wide word `a[9:2]` and lane `a[1:0]`. Lane k occupies wide data bits `4k+3:4k`, so lane 0 is bits 3:0.
- R2: A 16-bit word written through the wide port reads back through the narrow port as its four nibbles, mapped as in R1.
- R3: Four nibbles written through the narrow port into one wide word read back through the wide port as that assembled 16-bit word.
- R4: A port writes only on a rising edge of its clock where its enable and write enable are both high. With enable low, that port writes nothing and its read data output holds its value.
- R5: Reads are synchronous. Read data changes only at the port clock edge that samples enable high, and it stays steady between edges while the address changes.
- R6: Within one port, a write returns the contents the addressed location held before that edge (read-before-write).
- R7: A port's reset, sampled high at its clock edge, sets that port's read data to zero on that edge. Reset takes precedence over the read. It changes no stored data, and the other port is unaffected.
- R8: Both ports can write different words in the same cycle, and both writes take effect.
- R9: If both ports write the same bits at the same edge of a shared clock, the wide port's data is kept.
- R10: A port reading a location that the other port writes at the same edge returns the old contents. The next read returns the new contents.
- R11: With the narrow address MSB held high and the wide address MSB held low, traffic on either port never alters what the other port reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Narrow port clock |
| en_a | input | 1 | Narrow port enable |
| we_a | input | 1 | Narrow port write enable |
| rst_a | input | 1 | Narrow port synchronous read-data reset |
| addr_a | input | 10 | Narrow port word address |
| din_a | input | 4 | Narrow port write data |
| dout_a | output | 4 | Narrow port registered read data |
| clk_b | input | 1 | Wide port clock |
| en_b | input | 1 | Wide port enable |
| we_b | input | 1 | Wide port write enable |
| rst_b | input | 1 | Wide port synchronous read-data reset |
| addr_b | input | 8 | Wide port word address |
| din_b | input | 16 | Wide port write data |
| dout_b | output | 16 | Wide port registered read data |

## Verification
Suppose one bank is corrupted, or a write goes into the wrong lane. The fault is invisible until some port reads the affected word, and then the registered output shows it on the following edge. A bench that reads sparsely could miss it for a long time, so the reference model follows every location and compares both outputs after every edge. A collision that lets the narrow port win, or that mixes the two writes, shows as a wrong nibble on the very next read of that word through either port.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  // Address width for a count of items; never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Least significant bit of a lane inside a wide word.
  function automatic int lane_base(input int lane, input int lane_w);
    return lane * lane_w;
  endfunction

  // Which lane group (port-word slot) a given lane belongs to.
  function automatic int lane_slot(input int lane, input int lanes_per_slot);
    return lane / lanes_per_slot;
  endfunction

endpackage

// File: rtl/mwram_bank.sv
module mwram_bank
  import mwram_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 256,
  parameter int LANE_W = 4,
  localparam int LANES = WORD_W / LANE_W,
  localparam int AW    = idx_w(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd0_addr,
  output logic [WORD_W-1:0] rd0_data,
  input  logic [AW-1:0]     rd1_addr,
  output logic [WORD_W-1:0] rd1_data
);

  // Single-writer storage: only this bank's owning port clock writes it.
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l])
          store[wr_addr][lane_base(l, LANE_W) +: LANE_W] <= wr_data[lane_base(l, LANE_W) +: LANE_W];
      end
    end
  end

  assign rd0_data = store[rd0_addr];
  assign rd1_data = store[rd1_addr];

endmodule

// File: rtl/mwram_port.sv
module mwram_port
  import mwram_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 256,
  parameter int LANE_W = 4,
  parameter int PORT_W = 4,
  localparam int PER_WORD = WORD_W / PORT_W,
  localparam int SUB_W    = idx_w(PER_WORD),
  localparam int WAW      = idx_w(DEPTH),
  localparam int PAW      = WAW + ((PER_WORD > 1) ? SUB_W : 0),
  localparam int LANES    = WORD_W / LANE_W,
  localparam int LPP      = PORT_W / LANE_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic              rst,
  input  logic [PAW-1:0]    addr,
  input  logic [PORT_W-1:0] din,
  input  logic [WORD_W-1:0] own_word,
  input  logic [WORD_W-1:0] peer_word,
  input  logic [LANES-1:0]  yield_lanes,
  output logic [WAW-1:0]    word_addr,
  output logic              wr_en,
  output logic [LANES-1:0]  wr_lanes,
  output logic [WORD_W-1:0] wr_data,
  output logic [PORT_W-1:0] dout
);

  logic [SUB_W-1:0]  sub;
  logic [LANES-1:0]  sel_lanes;
  logic [WORD_W-1:0] merged;
  logic [PORT_W-1:0] rd_slice;

  // Split the port address into wide-word index and slot inside that word.
  generate
    if (PER_WORD > 1) begin : g_narrow
      assign sub       = addr[SUB_W-1:0];
      assign word_addr = addr[PAW-1:SUB_W];
    end else begin : g_full
      assign sub       = '0;
      assign word_addr = addr;
    end
  endgenerate

  always_comb begin
    for (int l = 0; l < LANES; l++)
      sel_lanes[l] = (lane_slot(l, LPP) == int'(sub));
  end

  // Lanes claimed by the other port at this edge are left to it.
  assign wr_lanes = sel_lanes & ~yield_lanes;
  assign wr_en    = en & we & (|wr_lanes);
  // Stored value is the XOR of both banks, so pre-cancel the peer's bits.
  assign wr_data  = {PER_WORD{din}} ^ peer_word;

  assign merged   = own_word ^ peer_word;
  assign rd_slice = merged[sub*PORT_W +: PORT_W];

  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else if (en)
      dout <= rd_slice;
  end

endmodule

// File: rtl/mwram_tdp.sv
module mwram_tdp
  import mwram_pkg::*;
#(
  parameter int NARROW_W   = 4,
  parameter int WIDE_W     = 16,
  parameter int TOTAL_BITS = 4096,
  localparam int WIDE_DEPTH   = TOTAL_BITS / WIDE_W,
  localparam int NARROW_DEPTH = TOTAL_BITS / NARROW_W,
  localparam int NAW          = idx_w(NARROW_DEPTH),
  localparam int WAW          = idx_w(WIDE_DEPTH),
  localparam int LANES        = WIDE_W / NARROW_W
) (
  input  logic                clk_a,
  input  logic                en_a,
  input  logic                we_a,
  input  logic                rst_a,
  input  logic [NAW-1:0]      addr_a,
  input  logic [NARROW_W-1:0] din_a,
  output logic [NARROW_W-1:0] dout_a,
  input  logic                clk_b,
  input  logic                en_b,
  input  logic                we_b,
  input  logic                rst_b,
  input  logic [WAW-1:0]      addr_b,
  input  logic [WIDE_W-1:0]   din_b,
  output logic [WIDE_W-1:0]   dout_b
);

  logic [WAW-1:0]    a_word,    b_word;
  logic              a_wr_en,   b_wr_en;
  logic [LANES-1:0]  a_lanes,   b_lanes;
  logic [WIDE_W-1:0] a_wr_data, b_wr_data;
  logic [WIDE_W-1:0] a_own, a_peer, b_own, b_peer;
  logic [LANES-1:0]  a_yield;
  logic              collide;

  // Wide port wins shared bits: narrow port gives up lanes the wide port writes now.
  assign a_yield = (b_wr_en && (a_word == b_word)) ? b_lanes : '0;
  assign collide = en_a & we_a & (|a_yield);

  mwram_port #(
    .WORD_W(WIDE_W), .DEPTH(WIDE_DEPTH), .LANE_W(NARROW_W), .PORT_W(NARROW_W)
  ) u_port_a (
    .clk(clk_a), .en(en_a), .we(we_a), .rst(rst_a), .addr(addr_a), .din(din_a),
    .own_word(a_own), .peer_word(a_peer), .yield_lanes(a_yield),
    .word_addr(a_word), .wr_en(a_wr_en), .wr_lanes(a_lanes), .wr_data(a_wr_data),
    .dout(dout_a)
  );

  mwram_port #(
    .WORD_W(WIDE_W), .DEPTH(WIDE_DEPTH), .LANE_W(NARROW_W), .PORT_W(WIDE_W)
  ) u_port_b (
    .clk(clk_b), .en(en_b), .we(we_b), .rst(rst_b), .addr(addr_b), .din(din_b),
    .own_word(b_own), .peer_word(b_peer), .yield_lanes({LANES{1'b0}}),
    .word_addr(b_word), .wr_en(b_wr_en), .wr_lanes(b_lanes), .wr_data(b_wr_data),
    .dout(dout_b)
  );

  mwram_bank #(.WORD_W(WIDE_W), .DEPTH(WIDE_DEPTH), .LANE_W(NARROW_W)) u_bank_a (
    .clk(clk_a), .wr_en(a_wr_en), .wr_addr(a_word), .wr_lanes(a_lanes), .wr_data(a_wr_data),
    .rd0_addr(a_word), .rd0_data(a_own), .rd1_addr(b_word), .rd1_data(b_peer)
  );

  mwram_bank #(.WORD_W(WIDE_W), .DEPTH(WIDE_DEPTH), .LANE_W(NARROW_W)) u_bank_b (
    .clk(clk_b), .wr_en(b_wr_en), .wr_addr(b_word), .wr_lanes(b_lanes), .wr_data(b_wr_data),
    .rd0_addr(b_word), .rd0_data(b_own), .rd1_addr(a_word), .rd1_data(a_peer)
  );

endmodule

// File: rtl/mwram_tdp_chk.sv
module mwram_tdp_chk #(
  parameter int NARROW_W = 4,
  parameter int WIDE_W   = 16,
  parameter int WAW      = 8,
  parameter int LANES    = 4
) (
  input logic                clk_a,
  input logic                clk_b,
  input logic                rst_a,
  input logic                rst_b,
  input logic                en_a,
  input logic                we_a,
  input logic                en_b,
  input logic                we_b,
  input logic [NARROW_W-1:0] dout_a,
  input logic [WIDE_W-1:0]   dout_b,
  input logic                a_wr_en,
  input logic                b_wr_en,
  input logic [WAW-1:0]      a_word,
  input logic [WAW-1:0]      b_word,
  input logic [LANES-1:0]    a_lanes,
  input logic [LANES-1:0]    b_lanes,
  input logic                collide
);

  p_rst_clears_a_r7: assert property (@(posedge clk_a) rst_a |=> (dout_a == '0));
  p_rst_clears_b_r7: assert property (@(posedge clk_b) rst_b |=> (dout_b == '0));

  p_idle_hold_a_r4: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable(dout_a));
  p_idle_hold_b_r4: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable(dout_b));

  p_write_gate_a_r4: assert property (@(posedge clk_a) disable iff (rst_a)
    a_wr_en |-> (en_a && we_a));
  p_write_gate_b_r4: assert property (@(posedge clk_b) disable iff (rst_b)
    b_wr_en |-> (en_b && we_b));

  // R9: no bit may be written by both banks at one edge.
  p_wide_wins_r9: assert property (@(posedge clk_a) disable iff (rst_a)
    !(a_wr_en && b_wr_en && (a_word == b_word) && ((a_lanes & b_lanes) != '0)));
  p_collide_yields_r9: assert property (@(posedge clk_a) disable iff (rst_a)
    (collide && (a_word == b_word)) |-> ((a_lanes & b_lanes) == '0));

endmodule

bind mwram_tdp mwram_tdp_chk #(
  .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .WAW(WAW), .LANES(LANES)
) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a(rst_a), .rst_b(rst_b),
  .en_a(en_a), .we_a(we_a), .en_b(en_b), .we_b(we_b),
  .dout_a(dout_a), .dout_b(dout_b),
  .a_wr_en(a_wr_en), .b_wr_en(b_wr_en), .a_word(a_word), .b_word(b_word),
  .a_lanes(a_lanes), .b_lanes(b_lanes), .collide(collide)
);

// File: tb/mwram_tdp_tb_top.sv
`timescale 1ns/1ps
module mwram_tdp_tb_top;

  logic        clk = 1'b0;
  logic        en_a, we_a, rst_a, en_b, we_b, rst_b;
  logic [9:0]  addr_a;
  logic [3:0]  din_a, dout_a;
  logic [7:0]  addr_b;
  logic [15:0] din_b, dout_b;

  always #2 clk = ~clk;

  mwram_tdp dut_i (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(dout_b)
  );

  // Behavioural reference: 256 words of 16 bits, plus known-lane flags.
  logic [15:0] ref_mem [256];
  logic [3:0]  ref_ok  [256];
  logic [3:0]  exp_a;
  logic [15:0] exp_b;
  bit          known_a, known_b, done;
  int          compared, mismatched;
  string       req;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [15:0] fill_pat(input int w);
    return {8'(w) ^ 8'hA5, 8'(w * 3 + 1)};
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check_now;
    if (known_a) begin
      compared++;
      if (dout_a !== exp_a) begin
        mismatched++;
        $display("FAIL %s port A: got %h expected %h", req, dout_a, exp_a);
      end
    end
    if (known_b) begin
      compared++;
      if (dout_b !== exp_b) begin
        mismatched++;
        $display("FAIL %s port B: got %h expected %h", req, dout_b, exp_b);
      end
    end
  endtask

  // One clock: drive at the falling edge, predict the rising edge, compare after it.
  task automatic cyc(input bit ea, input bit wa, input bit ra, input logic [9:0] aa,
                     input logic [3:0] da, input bit eb, input bit wb, input bit rb,
                     input logic [7:0] ab, input logic [15:0] db);
    int aw, al;
    en_a = ea; we_a = wa; rst_a = ra; addr_a = aa; din_a = da;
    en_b = eb; we_b = wb; rst_b = rb; addr_b = ab; din_b = db;
    aw = int'(aa) / 4;
    al = int'(aa) % 4;
    if (ra) begin exp_a = '0; known_a = 1'b1; end
    else if (ea) begin exp_a = ref_mem[aw][al*4 +: 4]; known_a = ref_ok[aw][al]; end
    if (rb) begin exp_b = '0; known_b = 1'b1; end
    else if (eb) begin exp_b = ref_mem[ab]; known_b = &ref_ok[ab]; end
    if (ea && wa) begin ref_mem[aw][al*4 +: 4] = da; ref_ok[aw][al] = 1'b1; end
    if (eb && wb) begin ref_mem[ab] = db; ref_ok[ab] = 4'hF; end
    @(posedge clk);
    @(negedge clk);
    check_now();
  endtask

  task automatic idle;
    cyc(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
  endtask

  initial begin
    en_a = 0; we_a = 0; rst_a = 1; addr_a = '0; din_a = '0;
    en_b = 0; we_b = 0; rst_b = 1; addr_b = '0; din_b = '0;
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; ref_ok[i] = '0; end
    known_a = 0; known_b = 0; compared = 0; mismatched = 0; done = 0;
    exp_a = '0; exp_b = '0;
    @(negedge clk);

    req = "R7 reset state";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, '0, '0, 0, 0, 1, '0, '0);

    req = "R2 wide fill";
    for (int w = 0; w < 256; w++) cyc(0, 0, 0, '0, '0, 1, 1, 0, 8'(w), fill_pat(w));

    req = "R1 R2 narrow view of wide words";
    foreach (ref_ok[i]) ;
    cyc(1, 0, 0, 10'd0, '0, 0, 0, 0, '0, '0);
    cyc(1, 0, 0, 10'd1, '0, 0, 0, 0, '0, '0);
    cyc(1, 0, 0, 10'd2, '0, 0, 0, 0, '0, '0);
    cyc(1, 0, 0, 10'd3, '0, 0, 0, 0, '0, '0);
    cyc(1, 0, 0, 10'd511, '0, 0, 0, 0, '0, '0);
    cyc(1, 0, 0, 10'd512, '0, 0, 0, 0, '0, '0);
    cyc(1, 0, 0, 10'd1023, '0, 0, 0, 0, '0, '0);

    req = "R3 narrow writes assemble";
    for (int l = 0; l < 4; l++) cyc(1, 1, 0, 10'(8'h37 * 4 + l), 4'(l + 9), 0, 0, 0, '0, '0);
    cyc(0, 0, 0, '0, '0, 1, 0, 0, 8'h37, '0);

    req = "R4 disabled writes ignored";
    cyc(0, 1, 0, 10'(8'h37 * 4), 4'hE, 0, 1, 0, 8'h37, 16'hDEAD);
    cyc(0, 1, 0, 10'(8'h37 * 4 + 2), 4'h1, 0, 1, 0, 8'h38, 16'hBEEF);
    cyc(1, 0, 0, 10'(8'h37 * 4), '0, 1, 0, 0, 8'h37, '0);
    cyc(0, 0, 0, '0, '0, 1, 0, 0, 8'h38, '0);

    req = "R5 registered read";
    cyc(0, 0, 0, '0, '0, 1, 0, 0, 8'h05, '0);
    addr_b = 8'h06; en_b = 1'b1;
    #1;
    compared++;
    if (dout_b !== fill_pat(5)) begin
      mismatched++;
      $display("FAIL R5 port B before edge: got %h expected %h", dout_b, fill_pat(5));
    end
    cyc(0, 0, 0, '0, '0, 1, 0, 0, 8'h06, '0);

    req = "R6 read before write";
    cyc(1, 1, 0, 10'(8'h37 * 4 + 1), 4'h5, 0, 0, 0, '0, '0);
    cyc(0, 0, 0, '0, '0, 1, 1, 0, 8'h20, 16'h1357);
    cyc(1, 0, 0, 10'(8'h37 * 4 + 1), '0, 1, 0, 0, 8'h20, '0);

    req = "R7 port reset";
    cyc(1, 0, 1, 10'(8'h20 * 4), '0, 1, 0, 0, 8'h21, '0);
    cyc(1, 0, 0, 10'(8'h20 * 4), '0, 1, 0, 1, 8'h21, '0);
    cyc(1, 0, 0, 10'(8'h20 * 4 + 3), '0, 1, 0, 0, 8'h21, '0);

    req = "R8 simultaneous writes";
    cyc(1, 1, 0, 10'(8'h40 * 4 + 1), 4'hC, 1, 1, 0, 8'h41, 16'hA0B1);
    cyc(1, 0, 0, 10'(8'h41 * 4), '0, 1, 0, 0, 8'h40, '0);

    req = "R9 same-bit collision";
    cyc(1, 1, 0, 10'(8'h10 * 4 + 2), 4'h3, 1, 1, 0, 8'h10, 16'h9F6E);
    cyc(1, 0, 0, 10'(8'h10 * 4 + 2), '0, 1, 0, 0, 8'h10, '0);

    req = "R10 cross-port read during write";
    cyc(1, 0, 0, 10'(8'h50 * 4 + 3), '0, 1, 1, 0, 8'h50, 16'h7C2D);
    cyc(1, 0, 0, 10'(8'h50 * 4 + 3), '0, 1, 1, 0, 8'h51, 16'h0F0F);
    cyc(0, 1, 0, 10'(8'h51 * 4 + 2), 4'hA, 1, 0, 0, 8'h51, '0);

    req = "R11 split halves";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      seed = next_rand(seed);
      r = seed;
      cyc(r[0], r[1], 1'b0, {1'b1, r[10:2]}, r[14:11],
          r[15], r[16], 1'b0, {1'b0, r[23:17]}, {r[31:24], r[31:24] ^ 8'h3C});
    end

    req = "R8 R9 R10 mixed traffic";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r, s;
      seed = next_rand(seed);
      r = seed;
      seed = next_rand(seed);
      s = seed;
      cyc(r[0], r[1], r[2] & r[3] & r[4], {2'b00, r[12:5]} | {s[1:0], 8'h00}, r[16:13],
          r[17], r[18], r[19] & r[20] & r[21], {s[1:0], r[23:22], r[27:24]}, s[31:16]);
    end

    idle();
    done = 1;
    report();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      report();
      $finish;
    end
  end

endmodule